// File: doc/BRIEF.md
# Chip-Wide Power, Reset and Pad-Enable Controller

This block keeps the few control bits that act on the whole chip and turns them into a clock-gate enable for the digital core, a timed reset sequence and output-enable levels for the pads. The power-down request can come from an external pin or from a register bit. A source-select bit picks which one is used and the other is ignored. The clock-gate enable is registered, so it cannot glitch. The register port is clocked outside the gated domain, so software can still reach the block while the core is frozen.

Writing the reset-trigger bit starts the same sequence as the reset pin. The configuration returns to its defaults, but a scratch byte with no defined reset value keeps its contents. A busy flag then stays high for a programmable number of cycles. The write that set the trigger is answered with a refusal, and so is every write that arrives while the sequence is running. Three pad controls decide which pads float: one floats the data pads, one forces the timing pads to stay driven, and one floats only the pixel-clock pad.

Top module: `glob_ctl_top`

## Requirements
- R1: When the source-select bit (address 0, bit 1) is 0, `pd_pin` alone decides power-down, and the register power-down bit (address 0, bit 2) has no effect on `core_clk_en`.
- R2: When the source-select bit is 1, the register power-down bit decides power-down (1 clears `core_clk_en`), and `pd_pin` has no effect.
- R3: A change on `pd_pin` reaches `core_clk_en` after SYNC_STAGES+1 rising edges. A change of the register power-down bit reaches it one edge after the write edge.
- R4: Register writes and reads work while `core_clk_en` is 0. An accepted write returns `host_nack` = 0.
- R5: The core leaves power-down when the register power-down bit is written back to 0, or when a pin reset (`rst`) returns the source to the pin and the pin is low.
- R6: Writing 1 to the reset-trigger bit (address 0, bit 0) gets `host_nack` = 1 and returns addresses 0 and 1 to 0x00. Address 0 bit 0 always reads 0. The scratch byte at address 2 keeps its value through both soft and pin reset.
- R7: After a trigger, `rst_busy` is high for exactly RST_CYCLES cycles. Any write while busy is refused (`host_nack` = 1) and changes nothing.
- R8: Output tristate bit (address 1, bit 0) = 1 drives `data_oe` and `timing_oe` low one cycle after the write.
- R9: The timing-force bit (address 1, bit 1) = 1 keeps `timing_oe` high even while the output tristate bit is 1.
- R10: The pixel-clock tristate bit (address 1, bit 2) = 1 drives only `pclk_oe` low.
- R11: After reset the registers read 0x00, `core_clk_en` is 1 (pin low) and all three output enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock for the register port and control logic |
| rst | input | 1 | Synchronous active-high reset pin; also starts the reset sequence |
| pd_pin | input | 1 | Asynchronous external power-down request, active high |
| host_we | input | 1 | Register write strobe |
| host_re | input | 1 | Register read strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid one cycle after `host_re` |
| host_nack | output | 1 | High one cycle after a refused write |
| rst_busy | output | 1 | Reset sequence in progress; core held in reset |
| core_clk_en | output | 1 | Registered clock-gate enable for the digital core |
| data_oe | output | 1 | Output enable of the data pads |
| timing_oe | output | 1 | Output enable of the HS, VS, FIELD and SFL pads |
| pclk_oe | output | 1 | Output enable of the pixel-clock pad |

## Verification
The power-down path is driven four ways: the pin toggled with source select at 0 and the register bit set, the pin held high with source select at 1, the register bit toggled with the pin high, and a pin reset from a powered-down state. Together these show which source is really in control and confirm the latency of each path. The pad bits are stepped through tristate alone, tristate with force, pixel-clock alone, and all together, which separates the effect of the force bit from the shared tristate. A soft reset is issued with non-default settings and a loaded scratch byte, and a write is sent during the busy window. This shows at once that the defaults return, that the scratch byte is kept, that the busy window has the right length, and that writes are refused during it.

// File: rtl/glob_ctl_pkg.sv
package glob_ctl_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_PAD  = 2'd1;
  localparam logic [ADDR_W-1:0] A_SCR  = 2'd2;

  // control register bit positions
  localparam int B_RST = 0;
  localparam int B_SEL = 1;
  localparam int B_PD  = 2;
  // pad register bit positions
  localparam int B_TRI   = 0;
  localparam int B_FORCE = 1;
  localparam int B_PCLK  = 2;

  typedef struct packed {
    logic pd_sel;
    logic pd_bit;
    logic out_tri;
    logic tim_force;
    logic pclk_tri;
  } cfg_t;

  localparam cfg_t CFG_DEF = '0;
endpackage

// File: rtl/glob_sync.sv
module glob_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)         st[g] <= '0;
      else if (g == 0) st[g] <= d;
      else             st[g] <= st[(g == 0) ? 0 : g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/glob_rst_seq.sv
module glob_rst_seq #(
  parameter int CYC = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC);
  localparam logic [CW-1:0] LOAD = CW'(CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/glob_regs.sv
module glob_regs
  import glob_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  output logic [DATA_W-1:0] rdata,
  output logic              nack,
  output logic              soft_start,
  output cfg_t              cfg
);
  logic              accept;
  logic [DATA_W-1:0] scratch;

  assign accept     = we && !busy;
  assign soft_start = accept && (addr == A_CTRL) && wdata[B_RST];

  always_ff @(posedge clk) begin
    if (rst || soft_start) begin
      cfg <= CFG_DEF;
    end else if (accept) begin
      case (addr)
        A_CTRL: begin
          cfg.pd_sel <= wdata[B_SEL];
          cfg.pd_bit <= wdata[B_PD];
        end
        A_PAD: begin
          cfg.out_tri   <= wdata[B_TRI];
          cfg.tim_force <= wdata[B_FORCE];
          cfg.pclk_tri  <= wdata[B_PCLK];
        end
        default: ;
      endcase
    end
  end

  // scratch byte has no defined reset value: it survives every reset
  always_ff @(posedge clk) begin
    if (accept && addr == A_SCR) scratch <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) nack <= 1'b0;
    else     nack <= we && (busy || soft_start);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= '0;
      case (addr)
        A_CTRL: begin
          rdata[B_SEL] <= cfg.pd_sel;
          rdata[B_PD]  <= cfg.pd_bit;
        end
        A_PAD: begin
          rdata[B_TRI]   <= cfg.out_tri;
          rdata[B_FORCE] <= cfg.tim_force;
          rdata[B_PCLK]  <= cfg.pclk_tri;
        end
        A_SCR:   rdata <= scratch;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/glob_ctl_top.sv
module glob_ctl_top
  import glob_ctl_pkg::*;
#(
  parameter int RST_CYCLES  = 100000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pd_pin,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_nack,
  output logic              rst_busy,
  output logic              core_clk_en,
  output logic              data_oe,
  output logic              timing_oe,
  output logic              pclk_oe
);
  cfg_t cfg;
  logic soft_start;
  logic pd_sync;
  logic pd_req;
  logic pd_sel, pd_bit, out_tri, tim_force, pclk_tri;

  glob_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pd_pin), .q(pd_sync)
  );

  glob_rst_seq #(.CYC(RST_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .start(soft_start), .busy(rst_busy)
  );

  glob_regs u_regs (
    .clk(clk), .rst(rst), .we(host_we), .re(host_re), .addr(host_addr),
    .wdata(host_wdata), .busy(rst_busy), .rdata(host_rdata),
    .nack(host_nack), .soft_start(soft_start), .cfg(cfg)
  );

  assign pd_sel    = cfg.pd_sel;
  assign pd_bit    = cfg.pd_bit;
  assign out_tri   = cfg.out_tri;
  assign tim_force = cfg.tim_force;
  assign pclk_tri  = cfg.pclk_tri;

  assign pd_req = pd_sel ? pd_bit : pd_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      core_clk_en <= 1'b1;
      data_oe     <= 1'b1;
      timing_oe   <= 1'b1;
      pclk_oe     <= 1'b1;
    end else begin
      core_clk_en <= !pd_req;
      data_oe     <= !out_tri;
      timing_oe   <= !out_tri || tim_force;
      pclk_oe     <= !pclk_tri;
    end
  end
endmodule

// File: rtl/glob_ctl_chk.sv
module glob_ctl_chk (
  input logic clk,
  input logic rst,
  input logic host_we,
  input logic host_nack,
  input logic rst_busy,
  input logic core_clk_en,
  input logic data_oe,
  input logic timing_oe,
  input logic pclk_oe,
  input logic pd_sel,
  input logic pd_bit,
  input logic out_tri,
  input logic tim_force,
  input logic pclk_tri,
  input logic pd_sync
);
  AST_PIN_RULES: assert property (@(posedge clk) disable iff (rst)
    (!pd_sel && !pd_sync) |=> core_clk_en); // R1
  AST_BIT_RULES: assert property (@(posedge clk) disable iff (rst)
    (pd_sel && pd_bit) |=> !core_clk_en); // R2
  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (rst_busy && host_we) |=> host_nack); // R7
  AST_SOFT_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_busy) |-> (!pd_sel && !pd_bit && !out_tri && !tim_force && !pclk_tri)); // R6
  AST_DATA_FLOAT: assert property (@(posedge clk) disable iff (rst)
    out_tri |=> !data_oe); // R8
  AST_TIMING_FORCE: assert property (@(posedge clk) disable iff (rst)
    tim_force |=> timing_oe); // R9
  AST_PCLK_FLOAT: assert property (@(posedge clk) disable iff (rst)
    pclk_tri |=> !pclk_oe); // R10
endmodule

bind glob_ctl_top glob_ctl_chk u_chk (
  .clk(clk), .rst(rst), .host_we(host_we), .host_nack(host_nack),
  .rst_busy(rst_busy), .core_clk_en(core_clk_en), .data_oe(data_oe),
  .timing_oe(timing_oe), .pclk_oe(pclk_oe), .pd_sel(pd_sel),
  .pd_bit(pd_bit), .out_tri(out_tri), .tim_force(tim_force),
  .pclk_tri(pclk_tri), .pd_sync(pd_sync)
);

// File: tb/glob_ctl_top_test.sv
module glob_ctl_top_test;
  localparam int N = 16;
  localparam logic [7:0] M_NACK = 8'h40, M_BUSY = 8'h20, M_CLK = 8'h10, M_OE = 8'h07;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pd_pin = 1'b0;
  logic       host_we = 1'b0, host_re = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       host_nack, rst_busy, core_clk_en, data_oe, timing_oe, pclk_oe;

  always #10 clk = ~clk;

  glob_ctl_top #(.RST_CYCLES(N)) uut (
    .clk(clk), .rst(rst), .pd_pin(pd_pin), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_nack(host_nack), .rst_busy(rst_busy), .core_clk_en(core_clk_en),
    .data_oe(data_oe), .timing_oe(timing_oe), .pclk_oe(pclk_oe)
  );

  typedef struct {
    string      req;
    int         kind;   // 0 read data, 1 status byte, 2 supplied value
    logic [7:0] mask;
    logic [7:0] exp;
    logic [7:0] act;
  } item_t;

  item_t      sb[$];
  item_t      it;
  logic [7:0] obs;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  function automatic logic [7:0] status();
    return {1'b0, host_nack, rst_busy, core_clk_en, 1'b0, data_oe, timing_oe, pclk_oe};
  endfunction

  // monitor: compares queued expectations in the middle of the low phase
  always @(negedge clk) begin
    #5;
    while (sb.size() > 0) begin
      it  = sb.pop_front();
      obs = (it.kind == 0) ? host_rdata : (it.kind == 1) ? status() : it.act;
      obs = obs & it.mask;
      total++;
      if (obs !== it.exp) begin
        bad++;
        $display("FAIL %s: actual %h expected %h", it.req, obs, it.exp);
      end
    end
  end

  task automatic exp_st(string r, logic [7:0] m, logic [7:0] e);
    sb.push_back('{r, 1, m, e, 8'h00});
  endtask
  task automatic exp_rd(string r, logic [7:0] e);
    sb.push_back('{r, 0, 8'hFF, e, 8'h00});
  endtask
  task automatic exp_val(string r, logic [7:0] a, logic [7:0] e);
    sb.push_back('{r, 2, 8'hFF, e, a});
  endtask
  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(logic [1:0] a, logic [7:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask
  task automatic rd(logic [1:0] a);
    host_re = 1'b1; host_addr = a;
    @(negedge clk);
    host_re = 1'b0;
  endtask
  task automatic wait_idle();
    for (int g = 0; g < 1000 && rst_busy; g++) tick(1);
  endtask
  task automatic pin_reset();
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    wait_idle();
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    int cnt;
    tick(3);
    rst = 1'b0;
    wait_idle();
    // R11 reset state
    exp_st("R11", 8'h77, 8'h17);
    rd(2'd0); exp_rd("R11", 8'h00);
    rd(2'd1); exp_rd("R11", 8'h00);

    // R1 pin in control, register bit ignored
    wr(2'd0, 8'h04);
    tick(2); exp_st("R1", M_CLK, 8'h10);
    rd(2'd0); exp_rd("R1", 8'h04);
    pd_pin = 1'b1;
    tick(2); exp_st("R3", M_CLK, 8'h10);
    tick(1); exp_st("R1", M_CLK, 8'h00);
    pd_pin = 1'b0;
    tick(3); exp_st("R3", M_CLK, 8'h10);

    // R2 register in control, pin ignored
    wr(2'd0, 8'h02);
    pd_pin = 1'b1;
    tick(5); exp_st("R2", M_CLK, 8'h10);
    wr(2'd0, 8'h06); exp_st("R3", M_CLK, 8'h10);
    tick(1); exp_st("R2", M_CLK, 8'h00);

    // R4 port alive in power-down
    wr(2'd2, 8'hA5); exp_st("R4", M_NACK, 8'h00);
    rd(2'd2); exp_rd("R4", 8'hA5);
    wr(2'd1, 8'h02);
    rd(2'd1); exp_rd("R4", 8'h02);
    exp_st("R4", M_CLK, 8'h00);

    // R5 leaving power-down
    wr(2'd0, 8'h02);
    tick(1); exp_st("R5", M_CLK, 8'h10);
    wr(2'd0, 8'h06);
    tick(1); exp_st("R5", M_CLK, 8'h00);
    pd_pin = 1'b0;
    pin_reset();
    exp_st("R5", M_CLK, 8'h10);
    rd(2'd0); exp_rd("R5", 8'h00);
    rd(2'd2); exp_rd("R6", 8'hA5);
    rd(2'd1); exp_rd("R11", 8'h00);

    // R8 R9 R10 pad enables
    wr(2'd1, 8'h01); tick(1); exp_st("R8", M_OE, 8'h01);
    wr(2'd1, 8'h03); tick(1); exp_st("R9", M_OE, 8'h03);
    wr(2'd1, 8'h04); tick(1); exp_st("R10", M_OE, 8'h06);
    wr(2'd1, 8'h07); tick(1); exp_st("R10", M_OE, 8'h02);
    wr(2'd1, 8'h00); tick(1); exp_st("R8", M_OE, 8'h07);

    // R6 R7 soft reset
    wr(2'd1, 8'h05);
    wr(2'd0, 8'h02);
    wr(2'd2, 8'h3C);
    wr(2'd0, 8'h03); exp_st("R6", M_NACK | M_BUSY, 8'h60);
    cnt = 1;
    wr(2'd1, 8'h01); exp_st("R7", M_NACK | M_BUSY, 8'h60);
    cnt++;
    for (int g = 0; g < 1000 && rst_busy; g++) begin
      tick(1);
      if (rst_busy) cnt++;
    end
    exp_val("R7", 8'(cnt), 8'(N));
    rd(2'd0); exp_rd("R6", 8'h00);
    rd(2'd1); exp_rd("R7", 8'h00);
    rd(2'd2); exp_rd("R6", 8'h3C);
    exp_st("R6", M_OE | M_CLK, 8'h17);
    wr(2'd1, 8'h01); exp_st("R7", M_NACK, 8'h00);
    rd(2'd1); exp_rd("R7", 8'h01);

    tick(2);
    done = 1'b1;
    finish_run();
  end
endmodule